// File: doc/BRIEF.md
# Per-Thread Fetch Line Buffer and Instruction Packer

This block sits at the front of a multithreaded instruction fetch stage. Each thread has a single buffer that holds one 64-byte instruction-cache line. In a fetch cycle the thread named by the caller presents its program counter. If the buffer already holds the line, the block slices up to a fetch-width of consecutive 32-bit instructions out of it, starting at the PC's word offset. These appear on contiguous, valid-qualified output slots, each tagged with its own PC. The block also reports how many slots are valid and what the following PC is.

When the line is missing, the block requests it from the instruction cache on a valid/ready port and parks the thread until the response comes back. A refused request is kept in one retry slot that is shared by all threads. While that slot is occupied it blocks every fetch and is offered to the cache again each cycle. The branch predictor, the quiesce decode, address translation and interrupt logic are all outside the block. They reach it as per-slot predicted-taken, target and quiesce flags, and as fault and interrupt inputs. A squash puts a thread back into normal operation.

Top module: `fetch_line_packer`

## Requirements
- R1: On a miss, the block raises `creq_valid` in the same cycle. `creq_addr` is then the fetch PC with its low six bits cleared, and `creq_tid` is the fetching thread.
- R2: No request is made, and slots are packed in the same cycle, when the thread's buffer is valid and its stored line address equals the aligned fetch PC.
- R3: After a miss request is accepted, the thread emits nothing until a response carrying its id arrives. That response fills its buffer, and later fetches of the line are packed. A response for a thread that is not awaiting one is discarded.
- R4: Slot i carries the line word at index PC[5:2]+i (word w sits at bits 32w+31..32w of the line) and the PC {PC[31:2],2'b00}+4i. Slots fill from slot 0 with no gaps. Packing stops at the end of the line or at the fetch width, and `slot_count` gives the number of valid slots.
- R5: A slot whose predicted-taken flag is set is emitted and is the last slot of the cycle. `next_pc` is then that slot's predicted target.
- R6: When no predicted-taken slot ends the group, `next_pc` is the PC of the last emitted slot plus 4.
- R7: A slot flagged quiesce is emitted and ends the group. Its thread then emits nothing and makes no request until it is squashed.
- R8: A refused request is held in one shared retry slot. The slot presents the same address and thread id every cycle, and no thread emits anything, until the cache accepts. The owner then waits for its response.
- R9: If the owner of the parked request is squashed before acceptance, acceptance only releases the block. The later response is discarded and the next fetch of that line requests it again.
- R10: A translation fault on a fetch attempt emits exactly one slot: slot 0, with `slot_fault` set, instruction 32'h0000_0013 and the fetch PC. The thread then emits nothing until it is squashed.
- R11: While `irq_pending` is high and PC[1:0] is 00, a fetch emits nothing and starts no request.
- R12: After reset every buffer is empty and no slot or request is active. A squash returns its thread to normal fetching, and a fetch for that same thread in the squash cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Attempt a fetch this cycle |
| fetch_tid | input | 1 | Fetching thread |
| fetch_pc | input | 32 | Fetching thread's PC |
| xlat_fault | input | 1 | Translation fault for this fetch |
| irq_pending | input | 1 | Interrupt pending |
| squash_req | input | 1 | Squash a thread |
| squash_tid | input | 1 | Thread to squash |
| creq_valid | output | 1 | Cache line request valid |
| creq_ready | input | 1 | Cache accepts request |
| creq_addr | output | 32 | Line-aligned request address |
| creq_tid | output | 1 | Requesting thread |
| cresp_valid | input | 1 | Cache response valid |
| cresp_tid | input | 1 | Response thread |
| cresp_line | input | 512 | Response line data |
| br_taken | input | 4 | Per-slot predicted-taken flag |
| br_target | input | 128 | Per-slot predicted target |
| quiesce | input | 4 | Per-slot quiesce flag |
| slot_valid | output | 4 | Slot valid mask |
| slot_inst | output | 128 | Slot instruction words |
| slot_pc | output | 128 | Slot PCs |
| slot_fault | output | 1 | Slot 0 is a fault no-op |
| slot_count | output | 3 | Number of valid slots |
| next_pc | output | 32 | Updated PC |

## Verification
The packer is swept over every word offset in a line with no branch flags. This shows the line-end limit (offsets 13 to 15) apart from the width limit (offsets 0 to 12). A second sweep moves a predicted-taken flag through every slot position, and one case sets the flag on a slot beyond the line end. Together they show that only emitted slots can redirect `next_pc`. Refused requests are run both with the owner left alone and with the owner squashed while parked, and the two cases must differ: one fills the buffer, the other drops the response. Quiesce, fault and interrupt-hold cases each sample a fetch after the event, and for quiesce and fault also a fetch after the following squash.

// File: rtl/flp_pkg.sv
// Shared types for the fetch line packer.
// Assumes: one state value per thread, held by the top module.
package flp_pkg;

    typedef enum logic [2:0] {
        TS_RUN        = 3'd0,
        TS_WAIT_RETRY = 3'd1,
        TS_WAIT_RESP  = 3'd2,
        TS_QUIESCE    = 3'd3,
        TS_TRAP       = 3'd4
    } thr_state_e;

endpackage

// File: rtl/flp_line_store.sv
// Per-thread line buffers. Each holds one line, its tag and a valid bit.
// Assumes: alloc and fill never target the same thread in the same cycle.
module flp_line_store #(
    parameter int NTHREADS  = 2,
    parameter int LINE_BITS = 512,
    parameter int TAG_W     = 26,
    parameter int TID_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [TID_W-1:0]     alloc_tid,
    input  logic [TAG_W-1:0]     alloc_tag,
    input  logic                 fill_en,
    input  logic [TID_W-1:0]     fill_tid,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic [TID_W-1:0]     rd_tid,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [LINE_BITS-1:0] rd_data
);

    logic                 vld_q  [NTHREADS];
    logic [TAG_W-1:0]     tag_q  [NTHREADS];
    logic [LINE_BITS-1:0] data_q [NTHREADS];

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        // Tag and valid: cleared on reset, invalidated on alloc, set on fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[t] <= 1'b0;
                tag_q[t] <= '0;
            end else if (alloc_en && alloc_tid == TID_W'(t)) begin
                vld_q[t] <= 1'b0;
                tag_q[t] <= alloc_tag;
            end else if (fill_en && fill_tid == TID_W'(t)) begin
                vld_q[t] <= 1'b1;
            end
        end

        // Line data: captured whenever a fill targets this thread.
        always_ff @(posedge clk) begin
            if (fill_en && fill_tid == TID_W'(t)) begin
                data_q[t] <= fill_data;
            end
        end

        AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && fill_tid == TID_W'(t)) |=> vld_q[t]); // R3
    end

    assign rd_valid = vld_q[rd_tid];
    assign rd_tag   = tag_q[rd_tid];
    assign rd_data  = data_q[rd_tid];

endmodule

// File: rtl/flp_retry_slot.sv
// Single shared retry slot. It keeps one refused line request and the
// thread that owns it, and raises a block flag until the cache accepts.
// Assumes: park_en is only asserted while the slot is empty.
module flp_retry_slot #(
    parameter int ADDR_W = 32,
    parameter int TID_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_en,
    input  logic [ADDR_W-1:0] park_addr,
    input  logic [TID_W-1:0]  park_tid,
    input  logic              creq_ready,
    output logic              blocked,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [TID_W-1:0]  slot_tid,
    output logic              retry_done
);

    logic              blk_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TID_W-1:0]  tid_q;

    assign retry_done = blk_q && creq_ready;

    // Slot state: filled on park, released on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            addr_q <= '0;
            tid_q  <= '0;
        end else if (retry_done) begin
            blk_q <= 1'b0;
        end else if (park_en && !blk_q) begin
            blk_q  <= 1'b1;
            addr_q <= park_addr;
            tid_q  <= park_tid;
        end
    end

    assign blocked   = blk_q;
    assign slot_addr = addr_q;
    assign slot_tid  = tid_q;

    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && !creq_ready) |=> (blk_q && $stable(addr_q) && $stable(tid_q))); // R8

endmodule

// File: rtl/flp_packer.sv
// Combinational packer. It extracts consecutive words of a line starting
// at the PC's word offset and stops at the line end, the width, or the
// first predicted-taken or quiesce slot, which is itself kept.
// Assumes: the caller gates the outputs with its own hit qualifier.
module flp_packer #(
    parameter int FW     = 4,
    parameter int WORDS  = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic [WORDS*32-1:0] line_data,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [FW-1:0]       br_taken,
    input  logic [FW*ADDR_W-1:0] br_target,
    input  logic [FW-1:0]       quiesce,
    output logic [FW-1:0]       lane_valid,
    output logic [FW*32-1:0]    lane_inst,
    output logic [FW*ADDR_W-1:0] lane_pc,
    output logic [CNT_W-1:0]    lane_count,
    output logic [ADDR_W-1:0]   lane_next_pc,
    output logic                lane_qhit
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = OFF_W + 1;

    logic [ADDR_W-1:0] base_pc;
    logic [OFF_W-1:0]  off;

    assign base_pc = {pc[ADDR_W-1:2], 2'b00};
    assign off     = pc[OFF_W+1:2];

    // Walk the lanes in order and stop at the first terminating condition.
    always_comb begin : p_pack
        logic              stop;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] lpc;
        stop         = 1'b0;
        lane_valid   = '0;
        lane_inst    = '0;
        lane_pc      = '0;
        lane_count   = '0;
        lane_next_pc = base_pc;
        lane_qhit    = 1'b0;
        for (int i = 0; i < FW; i++) begin
            idx = {1'b0, off} + IDX_W'(i);
            lpc = base_pc + ADDR_W'(i * 4);
            if (!stop && idx < IDX_W'(WORDS)) begin
                lane_valid[i]              = 1'b1;
                lane_inst[i*32 +: 32]      = line_data[idx[OFF_W-1:0]*32 +: 32];
                lane_pc[i*ADDR_W +: ADDR_W] = lpc;
                lane_count                 = lane_count + 1'b1;
                lane_next_pc               = br_taken[i] ? br_target[i*ADDR_W +: ADDR_W]
                                                         : lpc + ADDR_W'(4);
                lane_qhit                  = lane_qhit | quiesce[i];
                if (br_taken[i] || quiesce[i]) begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fetch_line_packer.sv
// Top of the fetch line buffer and packer. It keeps the per-thread state,
// decides hit, miss, fault or hold for each fetch, drives the cache
// request port and muxes the output slots.
// Assumes: at most one fetching thread per cycle; external logic supplies
// branch and quiesce flags per output slot.
module fetch_line_packer #(
    parameter int          NTHREADS   = 2,
    parameter int          FW         = 4,
    parameter int          LINE_BYTES = 64,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] NOP_WORD   = 32'h0000_0013,
    localparam int         TID_W      = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int         WORDS      = LINE_BYTES / 4,
    localparam int         LINE_BITS  = LINE_BYTES * 8,
    localparam int         CNT_W      = $clog2(FW + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_req,
    input  logic [TID_W-1:0]     fetch_tid,
    input  logic [ADDR_W-1:0]    fetch_pc,
    input  logic                 xlat_fault,
    input  logic                 irq_pending,
    input  logic                 squash_req,
    input  logic [TID_W-1:0]     squash_tid,
    output logic                 creq_valid,
    input  logic                 creq_ready,
    output logic [ADDR_W-1:0]    creq_addr,
    output logic [TID_W-1:0]     creq_tid,
    input  logic                 cresp_valid,
    input  logic [TID_W-1:0]     cresp_tid,
    input  logic [LINE_BITS-1:0] cresp_line,
    input  logic [FW-1:0]        br_taken,
    input  logic [FW*ADDR_W-1:0] br_target,
    input  logic [FW-1:0]        quiesce,
    output logic [FW-1:0]        slot_valid,
    output logic [FW*32-1:0]     slot_inst,
    output logic [FW*ADDR_W-1:0] slot_pc,
    output logic                 slot_fault,
    output logic [CNT_W-1:0]     slot_count,
    output logic [ADDR_W-1:0]    next_pc
);
    import flp_pkg::*;

    localparam int LOFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - LOFF_W;

    thr_state_e thr_q [NTHREADS];

    logic [TAG_W-1:0]     fetch_tag;
    logic [ADDR_W-1:0]    aligned_pc;
    logic                 rd_valid;
    logic [TAG_W-1:0]     rd_tag;
    logic [LINE_BITS-1:0] rd_data;
    logic                 blocked, retry_done;
    logic [ADDR_W-1:0]    rs_addr;
    logic [TID_W-1:0]     rs_tid;
    logic                 sq_same, irq_hold, attempt, hit;
    logic                 do_fault, do_pack, do_miss, park_en, fill_en;
    logic [FW-1:0]        lane_valid;
    logic [FW*32-1:0]     lane_inst;
    logic [FW*ADDR_W-1:0] lane_pc;
    logic [CNT_W-1:0]     lane_count;
    logic [ADDR_W-1:0]    lane_next_pc;
    logic                 lane_qhit;

    assign fetch_tag  = fetch_pc[ADDR_W-1:LOFF_W];
    assign aligned_pc = {fetch_tag, {LOFF_W{1'b0}}};

    // Classify this cycle's fetch attempt.
    assign sq_same  = squash_req && (squash_tid == fetch_tid);
    assign irq_hold = irq_pending && (fetch_pc[1:0] == 2'b00);
    assign attempt  = fetch_req && !sq_same && !blocked && !irq_hold
                      && (thr_q[fetch_tid] == TS_RUN);
    assign hit      = rd_valid && (rd_tag == fetch_tag);
    assign do_fault = attempt && xlat_fault;
    assign do_pack  = attempt && !xlat_fault && hit;
    assign do_miss  = attempt && !xlat_fault && !hit;
    assign park_en  = do_miss && !creq_ready;
    assign fill_en  = cresp_valid && (thr_q[cresp_tid] == TS_WAIT_RESP);

    flp_line_store #(
        .NTHREADS (NTHREADS),
        .LINE_BITS(LINE_BITS),
        .TAG_W    (TAG_W),
        .TID_W    (TID_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (do_miss),
        .alloc_tid(fetch_tid),
        .alloc_tag(fetch_tag),
        .fill_en  (fill_en),
        .fill_tid (cresp_tid),
        .fill_data(cresp_line),
        .rd_tid   (fetch_tid),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data)
    );

    flp_retry_slot #(
        .ADDR_W(ADDR_W),
        .TID_W (TID_W)
    ) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .park_en   (park_en),
        .park_addr (aligned_pc),
        .park_tid  (fetch_tid),
        .creq_ready(creq_ready),
        .blocked   (blocked),
        .slot_addr (rs_addr),
        .slot_tid  (rs_tid),
        .retry_done(retry_done)
    );

    flp_packer #(
        .FW    (FW),
        .WORDS (WORDS),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_pack (
        .line_data   (rd_data),
        .pc          (fetch_pc),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .quiesce     (quiesce),
        .lane_valid  (lane_valid),
        .lane_inst   (lane_inst),
        .lane_pc     (lane_pc),
        .lane_count  (lane_count),
        .lane_next_pc(lane_next_pc),
        .lane_qhit   (lane_qhit)
    );

    // Cache request port: the parked request has priority over new misses.
    always_comb begin
        creq_valid = blocked || do_miss;
        creq_addr  = blocked ? rs_addr : aligned_pc;
        creq_tid   = blocked ? rs_tid  : fetch_tid;
    end

    // Output slot mux: packed group, single fault no-op, or nothing.
    always_comb begin
        slot_valid = '0;
        slot_inst  = '0;
        slot_pc    = '0;
        slot_fault = 1'b0;
        slot_count = '0;
        next_pc    = fetch_pc;
        if (do_pack) begin
            slot_valid = lane_valid;
            slot_inst  = lane_inst;
            slot_pc    = lane_pc;
            slot_count = lane_count;
            next_pc    = lane_next_pc;
        end else if (do_fault) begin
            slot_valid[0]        = 1'b1;
            slot_inst[31:0]      = NOP_WORD;
            slot_pc[ADDR_W-1:0]  = {fetch_pc[ADDR_W-1:2], 2'b00};
            slot_fault           = 1'b1;
            slot_count           = CNT_W'(1);
        end
    end

    for (genvar t = 0; t < NTHREADS; t++) begin : g_state
        // Thread state: squash first, then fill, retry acceptance, fetch events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q[t] <= TS_RUN;
            end else if (squash_req && squash_tid == TID_W'(t)) begin
                thr_q[t] <= TS_RUN;
            end else if (fill_en && cresp_tid == TID_W'(t)) begin
                thr_q[t] <= TS_RUN;
            end else if (retry_done && rs_tid == TID_W'(t) && thr_q[t] == TS_WAIT_RETRY) begin
                thr_q[t] <= TS_WAIT_RESP;
            end else if (fetch_tid == TID_W'(t)) begin
                if (do_miss) begin
                    thr_q[t] <= creq_ready ? TS_WAIT_RESP : TS_WAIT_RETRY;
                end else if (do_fault) begin
                    thr_q[t] <= TS_TRAP;
                end else if (do_pack && lane_qhit) begin
                    thr_q[t] <= TS_QUIESCE;
                end
            end
        end
    end

    AST_BLOCK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (slot_count == '0)); // R8

    AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_count != '0 && !slot_fault) |-> !creq_valid); // R2

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && irq_hold) |-> (slot_count == '0 && (blocked || !creq_valid))); // R11

    AST_SQUASH_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (thr_q[$past(squash_tid)] == TS_RUN)); // R12

endmodule

// File: tb/fetch_line_packer_tb.sv
module fetch_line_packer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_req = 1'b0;
    logic [0:0]   fetch_tid = '0;
    logic [31:0]  fetch_pc = '0;
    logic         xlat_fault = 1'b0;
    logic         irq_pending = 1'b0;
    logic         squash_req = 1'b0;
    logic [0:0]   squash_tid = '0;
    logic         creq_valid;
    logic         creq_ready = 1'b1;
    logic [31:0]  creq_addr;
    logic [0:0]   creq_tid;
    logic         cresp_valid = 1'b0;
    logic [0:0]   cresp_tid = '0;
    logic [511:0] cresp_line = '0;
    logic [3:0]   br_taken = '0;
    logic [127:0] br_target = '0;
    logic [3:0]   quiesce = '0;
    logic [3:0]   slot_valid;
    logic [127:0] slot_inst;
    logic [127:0] slot_pc;
    logic         slot_fault;
    logic [2:0]   slot_count;
    logic [31:0]  next_pc;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    fetch_line_packer u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_tid(fetch_tid),
        .fetch_pc(fetch_pc), .xlat_fault(xlat_fault), .irq_pending(irq_pending),
        .squash_req(squash_req), .squash_tid(squash_tid), .creq_valid(creq_valid),
        .creq_ready(creq_ready), .creq_addr(creq_addr), .creq_tid(creq_tid),
        .cresp_valid(cresp_valid), .cresp_tid(cresp_tid), .cresp_line(cresp_line),
        .br_taken(br_taken), .br_target(br_target), .quiesce(quiesce),
        .slot_valid(slot_valid), .slot_inst(slot_inst), .slot_pc(slot_pc),
        .slot_fault(slot_fault), .slot_count(slot_count), .next_pc(next_pc)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] word_of(int t, logic [31:0] line, int w);
        return 32'hC000_0000 ^ line ^ (32'(w) << 2) ^ (32'(t) << 20);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Advance to the next falling edge and return inputs to idle.
    task automatic step();
        @(negedge clk);
        fetch_req = 1'b0; xlat_fault = 1'b0; irq_pending = 1'b0;
        squash_req = 1'b0; cresp_valid = 1'b0; creq_ready = 1'b1;
        br_taken = '0; br_target = '0; quiesce = '0;
    endtask

    task automatic do_fetch(int t, logic [31:0] pc);
        fetch_req = 1'b1; fetch_tid = 1'(t); fetch_pc = pc;
    endtask

    task automatic respond(int t, logic [31:0] line);
        cresp_valid = 1'b1; cresp_tid = 1'(t);
        for (int w = 0; w < 16; w++) cresp_line[w*32 +: 32] = word_of(t, line, w);
    endtask

    // Fetch a resident line and compare the packed group with the model.
    task automatic expect_pack(string req, int t, logic [31:0] pc, int brpos, int qpos);
        int off; int n; logic [31:0] base; logic [31:0] line; logic [31:0] nxt;
        off  = int'(pc[5:2]);
        base = {pc[31:2], 2'b00};
        line = {pc[31:6], 6'b0};
        n    = (16 - off < 4) ? 16 - off : 4;
        if (brpos >= 0) begin
            br_taken[brpos] = 1'b1;
            br_target[brpos*32 +: 32] = 32'h2000 + 32'(brpos) * 32'h40;
        end
        if (qpos >= 0) quiesce[qpos] = 1'b1;
        if (brpos >= 0 && brpos < n) n = brpos + 1;
        if (qpos >= 0 && qpos < n) n = qpos + 1;
        nxt = (brpos >= 0 && brpos == n - 1) ? 32'h2000 + 32'(brpos) * 32'h40
                                             : base + 32'(4 * n);
        do_fetch(t, pc);
        #1;
        chk({req, " count"}, 64'(slot_count), 64'(n));
        chk({req, " valid"}, 64'(slot_valid), 64'((1 << n) - 1));
        chk({req, " next_pc"}, 64'(next_pc), 64'(nxt));
        chk({req, " R2 no request on hit"}, 64'(creq_valid), 64'(0));
        for (int i = 0; i < n; i++) begin
            chk({req, " slot pc"}, 64'(slot_pc[i*32 +: 32]), 64'(base + 32'(4 * i)));
            chk({req, " slot inst"}, 64'(slot_inst[i*32 +: 32]), 64'(word_of(t, line, off + i)));
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        #1;
        // R12: reset state
        chk("R12 reset count", 64'(slot_count), 64'(0));
        chk("R12 reset creq", 64'(creq_valid), 64'(0));

        // R1: first fetch misses and requests the aligned line
        step(); do_fetch(0, 32'h0000_1024); #1;
        chk("R1 creq_valid", 64'(creq_valid), 64'(1));
        chk("R1 creq_addr", 64'(creq_addr), 64'h1000);
        chk("R1 creq_tid", 64'(creq_tid), 64'(0));
        chk("R1 no slots on miss", 64'(slot_count), 64'(0));

        // R3: waiting thread emits nothing; stray response to thread 1 dropped
        step(); do_fetch(0, 32'h1024); respond(1, 32'h1000); #1;
        chk("R3 waiting count", 64'(slot_count), 64'(0));
        chk("R3 waiting no creq", 64'(creq_valid), 64'(0));
        step(); respond(0, 32'h1000);

        // R4 R6: sweep every word offset
        for (int o = 0; o < 16; o++) begin
            step(); expect_pack("R4 R6 offset sweep", 0, 32'h1000 + 32'(4 * o), -1, -1);
        end

        // R5: predicted-taken at each slot position
        for (int p = 0; p < 4; p++) begin
            step(); expect_pack("R5 taken sweep", 0, 32'h1008, p, -1);
        end
        step(); expect_pack("R5 taken beyond line end", 0, 32'h1038, 3, -1);

        // R3: thread 1 was never filled, so it misses
        step(); do_fetch(1, 32'h1004); creq_ready = 1'b0; #1;
        chk("R3 dropped response leaves miss", 64'(creq_valid), 64'(1));
        chk("R8 refused tid", 64'(creq_tid), 64'(1));
        // R8: retry slot blocks thread 0 hits
        for (int k = 0; k < 2; k++) begin
            step(); do_fetch(0, 32'h1000); creq_ready = 1'b0; #1;
            chk("R8 blocked count", 64'(slot_count), 64'(0));
            chk("R8 retry valid", 64'(creq_valid), 64'(1));
            chk("R8 retry addr", 64'(creq_addr), 64'h1000);
            chk("R8 retry tid", 64'(creq_tid), 64'(1));
        end
        step(); do_fetch(0, 32'h1000); #1;
        chk("R8 accept cycle still blocked", 64'(slot_count), 64'(0));
        chk("R8 accept cycle creq", 64'(creq_valid), 64'(1));
        step(); expect_pack("R8 released", 0, 32'h1000, -1, -1);
        step(); respond(1, 32'h1000);
        step(); expect_pack("R8 owner filled", 1, 32'h1004, -1, -1);

        // R9: owner squashed while parked
        step(); do_fetch(1, 32'h3000); creq_ready = 1'b0; #1;
        chk("R9 park creq", 64'(creq_valid), 64'(1));
        step(); squash_req = 1'b1; squash_tid = 1'b1; creq_ready = 1'b0; #1;
        chk("R9 still presented", 64'(creq_addr), 64'h3000);
        step(); #1;
        chk("R9 accepted", 64'(creq_valid), 64'(1));
        step(); respond(1, 32'h3000);
        step(); do_fetch(1, 32'h3000); #1;
        chk("R9 response dropped, re-request", 64'(creq_valid), 64'(1));
        chk("R9 re-request addr", 64'(creq_addr), 64'h3000);
        chk("R9 re-request no slots", 64'(slot_count), 64'(0));
        step(); respond(1, 32'h3000);
        step(); expect_pack("R9 refill", 1, 32'h3010, -1, -1);

        // R7: quiesce ends group and halts thread until squash
        step(); expect_pack("R7 quiesce", 0, 32'h1000, -1, 1);
        step(); do_fetch(0, 32'h1008); #1;
        chk("R7 halted count", 64'(slot_count), 64'(0));
        chk("R7 halted creq", 64'(creq_valid), 64'(0));
        step(); squash_req = 1'b1; squash_tid = 1'b0; do_fetch(0, 32'h1000); #1;
        chk("R12 fetch in squash cycle ignored", 64'(slot_count), 64'(0));
        step(); expect_pack("R12 resumes after squash", 0, 32'h1000, -1, -1);

        // R10: translation fault
        step(); do_fetch(0, 32'h1010); xlat_fault = 1'b1; #1;
        chk("R10 count", 64'(slot_count), 64'(1));
        chk("R10 valid", 64'(slot_valid), 64'(1));
        chk("R10 fault flag", 64'(slot_fault), 64'(1));
        chk("R10 nop", 64'(slot_inst[31:0]), 64'h13);
        chk("R10 pc", 64'(slot_pc[31:0]), 64'h1010);
        step(); do_fetch(0, 32'h1010); #1;
        chk("R10 trapped", 64'(slot_count), 64'(0));
        step(); squash_req = 1'b1; squash_tid = 1'b0;
        step(); expect_pack("R10 after squash", 0, 32'h1010, -1, -1);

        // R11: interrupt hold
        step(); do_fetch(0, 32'h1000); irq_pending = 1'b1; #1;
        chk("R11 hold count", 64'(slot_count), 64'(0));
        step(); do_fetch(0, 32'h5000); irq_pending = 1'b1; #1;
        chk("R11 no miss request", 64'(creq_valid), 64'(0));
        step(); irq_pending = 1'b1; expect_pack("R11 low bits set", 0, 32'h1001, -1, -1);

        step();
        finish_run();
    end

endmodule